// File: doc/BRIEF.md
# Power-Management Serial Bus Transaction Sequencer

This block sits between a host and one channel of a power-management serial bus controller. The host hands it one request at a time: a request kind (read, write or control), an 8-bit bus command code, a slave ID, a 16-bit register address, a byte count minus one and up to eight write bytes. The block sorts the command code into a small internal opcode set and refuses codes it cannot map. For accepted requests it drives a short sequence of accesses to the channel's registers: write data words, then a packed command word, then repeated status reads, then read-data words.

Status is read until the done bit appears or a poll budget runs out. Between polls the block waits a programmable number of system clocks, which is set to one microsecond's worth. The request ends with a one-cycle response carrying a result code and, for successful reads, the returned bytes. Only one request is in flight. The block reports busy from acceptance until its response.

Channel register select values: 0 command, 1 status, 2 write word 0, 3 write word 1, 4 read word 0, 5 read word 1. The channel returns read data one clock after a read strobe. Result codes: 0 success, 1 rejected, 2 denied, 3 failed, 4 dropped, 5 timeout. Request kinds: 0 read, 1 write, 2 control; kind 3 is rejected.

Top module: `pwrbus_txn_seq`

## Requirements
- R1: A read request maps command codes 0x60..0x7F to opcode 15, 0x20..0x2F to opcode 13 and 0x38..0x3F to opcode 1. Any other read code, and request kind 3, gives result 1 with no channel access.
- R2: A write request maps 0x40..0x5F to opcode 14, 0x00..0x0F to opcode 2, 0x30..0x37 to opcode 0 and 0x80..0xFF to opcode 16. Any other write code gives result 1 with no channel access.
- R3: A control request accepts only codes 0x10..0x13. Its opcode field holds the low five bits of the code ORed with 0x40, and it writes no data words. Any other control code gives result 1 with no channel access.
- R4: The command word has the opcode in [31:27] and the slave ID in [23:20]. For read and write requests it has the address in [19:4] and the byte count minus one in [2:0]. Every other bit is zero, and the address and count fields are zero for control requests.
- R5: A read or write request whose byte count minus one is 8 or more gives result 1 with no channel access.
- R6: A write request stores bytes 0..3 in write word 0, least significant byte first, and bytes 4..7 in write word 1. Bytes beyond the count are zero. Word 1 is written only when more than four bytes are sent. Both data words are written before the command word.
- R7: A read request reads word 0, and also word 1 when more than four bytes are requested, only after a successful completion. The response holds byte k in bits [8k+7:8k], and bytes beyond the count are zero. A response with any nonzero result code carries all-zero data.
- R8: Once status bit 0 (done) is seen, bit 2 gives result 2, else bit 1 gives result 3, else bit 3 gives result 4, else the result is 0.
- R9: Status reads without bit 0 are ignored whatever their other bits, and polling continues. After MAX_POLLS status reads without done, the result is 5, and exactly MAX_POLLS status reads are made. Done on the last allowed read is a success.
- R10: Consecutive status reads are cfg_us_div + 2 clocks apart, and a divider of 0 acts as 1.
- R11: busy rises in the cycle after a request is accepted and stays high through the single-cycle rsp_valid pulse. A request raised while busy is ignored.
- R12: After reset, busy and rsp_valid are low and no channel access is made until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_kind | input | 2 | 0 read, 1 write, 2 control |
| req_code | input | 8 | Bus command code |
| req_sid | input | SID_W | Slave ID |
| req_addr | input | ADDR_W | Register address |
| req_cnt_m1 | input | 4 | Byte count minus one |
| req_wdata | input | 64 | Write bytes, byte k in bits [8k+7:8k] |
| cfg_us_div | input | DIV_W | Clocks per microsecond between polls |
| busy | output | 1 | A request is in flight |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | Result code |
| rsp_rdata | output | 64 | Read bytes, zero-filled |
| ch_wr | output | 1 | Channel register write strobe |
| ch_rd | output | 1 | Channel register read strobe |
| ch_sel | output | 3 | Channel register select |
| ch_wdata | output | 32 | Channel write data |
| ch_rdata | input | 32 | Channel read data, valid one clock after ch_rd |

## Verification
The done flag and the end of the poll budget can fall on the same status read. The bench provokes this by having the channel model report done on exactly the MAX_POLLS-th read. It judges the outcome by expecting success rather than timeout, with exactly MAX_POLLS status reads and the read words fetched afterwards. A second overlap puts a new request on the host port while a transaction is still polling. The bench expects that request to be dropped, with one command word and one response only.

// File: rtl/pwrbus_pkg.sv
package pwrbus_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_CTRL  = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_REJECT  = 3'd1,
    RC_DENIED  = 3'd2,
    RC_FAILED  = 3'd3,
    RC_DROPPED = 3'd4,
    RC_TIMEOUT = 3'd5
  } rcode_e;

  localparam logic [2:0] CH_CMD    = 3'd0;
  localparam logic [2:0] CH_STATUS = 3'd1;
  localparam logic [2:0] CH_WD0    = 3'd2;
  localparam logic [2:0] CH_WD1    = 3'd3;
  localparam logic [2:0] CH_RD0    = 3'd4;
  localparam logic [2:0] CH_RD1    = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_WD0, S_WD1, S_CMD, S_POLL, S_PEVAL, S_WAIT,
    S_RD0, S_RD0C, S_RD1, S_RD1C, S_RESP
  } st_e;

endpackage

// File: rtl/pwrbus_opc_map.sv
module pwrbus_opc_map
  import pwrbus_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [7:0] code,
  output logic       ok,
  output logic [4:0] opc
);
  logic [7:0] ctrl_code;
  assign ctrl_code = code | 8'h40;

  always_comb begin
    ok  = 1'b0;
    opc = 5'd0;
    case (kind)
      KIND_READ: begin
        if (code inside {[8'h60:8'h7F]})      begin ok = 1'b1; opc = 5'd15; end
        else if (code inside {[8'h20:8'h2F]}) begin ok = 1'b1; opc = 5'd13; end
        else if (code inside {[8'h38:8'h3F]}) begin ok = 1'b1; opc = 5'd1;  end
      end
      KIND_WRITE: begin
        if (code inside {[8'h40:8'h5F]})      begin ok = 1'b1; opc = 5'd14; end
        else if (code inside {[8'h00:8'h0F]}) begin ok = 1'b1; opc = 5'd2;  end
        else if (code inside {[8'h30:8'h37]}) begin ok = 1'b1; opc = 5'd0;  end
        else if (code[7])                     begin ok = 1'b1; opc = 5'd16; end
      end
      KIND_CTRL: begin
        if (code inside {[8'h10:8'h13]}) begin ok = 1'b1; opc = ctrl_code[4:0]; end
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwrbus_cmd_pack.sv
module pwrbus_cmd_pack #(
  parameter int SID_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic [4:0]        opc,
  input  logic [SID_W-1:0]  sid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        cnt_m1,
  input  logic              ctrl,
  input  logic [63:0]       wdata,
  output logic [31:0]       cmd_word,
  output logic [31:0]       word0,
  output logic [31:0]       word1,
  output logic [63:0]       keep
);
  localparam int OPC_LSB  = 27;
  localparam int SID_LSB  = 20;
  localparam int ADDR_LSB = 4;
  localparam int NBYTES   = 8;

  for (genvar g = 0; g < NBYTES; g++) begin : g_keep
    assign keep[8*g +: 8] = (3'(g) <= cnt_m1) ? 8'hFF : 8'h00;
  end

  always_comb begin
    cmd_word = '0;
    cmd_word[OPC_LSB +: 5]     = opc;
    cmd_word[SID_LSB +: SID_W] = sid;
    if (!ctrl) begin
      cmd_word[ADDR_LSB +: ADDR_W] = addr;
      cmd_word[2:0]                = cnt_m1;
    end
  end

  assign word0 = wdata[31:0]  & keep[31:0];
  assign word1 = wdata[63:32] & keep[63:32];
endmodule

// File: rtl/pwrbus_status_dec.sv
module pwrbus_status_dec
  import pwrbus_pkg::*;
(
  input  logic [3:0] status,
  output logic       done,
  output logic       fault,
  output rcode_e     code
);
  assign done  = status[0];
  assign fault = status[0] & (|status[3:1]);

  always_comb begin
    if (status[2])      code = RC_DENIED;
    else if (status[1]) code = RC_FAILED;
    else if (status[3]) code = RC_DROPPED;
    else                code = RC_OK;
  end
endmodule

// File: rtl/pwrbus_poll_timer.sv
module pwrbus_poll_timer #(
  parameter int DIV_W     = 16,
  parameter int MAX_POLLS = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             arm,
  input  logic             tick_en,
  input  logic [DIV_W-1:0] div,
  output logic             wait_over,
  output logic             last_poll
);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [PW-1:0]    polls;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      polls <= '0;
      cnt   <= '0;
    end else begin
      if (clear)    polls <= '0;
      else if (arm) polls <= polls + 1'b1;
      if (arm)                       cnt <= (div == '0) ? DIV_W'(1) : div;
      else if (tick_en && cnt > 1)   cnt <= cnt - 1'b1;
    end
  end

  assign wait_over = (cnt <= DIV_W'(1));
  assign last_poll = (polls == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/pwrbus_txn_seq.sv
module pwrbus_txn_seq
  import pwrbus_pkg::*;
#(
  parameter int SID_W     = 4,
  parameter int ADDR_W    = 16,
  parameter int DIV_W     = 16,
  parameter int MAX_POLLS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [7:0]        req_code,
  input  logic [SID_W-1:0]  req_sid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_cnt_m1,
  input  logic [63:0]       req_wdata,
  input  logic [DIV_W-1:0]  cfg_us_div,
  output logic              busy,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [63:0]       rsp_rdata,
  output logic              ch_wr,
  output logic              ch_rd,
  output logic [2:0]        ch_sel,
  output logic [31:0]       ch_wdata,
  input  logic [31:0]       ch_rdata
);
  st_e               st;
  logic [1:0]        kind_q;
  logic [7:0]        code_q;
  logic [SID_W-1:0]  sid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cnt_q;
  logic [63:0]       wdata_q;
  logic [63:0]       rbuf;
  rcode_e            rcode_q;

  logic        map_ok;
  logic [4:0]  map_opc;
  logic [31:0] cmd_word, word0, word1;
  logic [63:0] keep;
  logic        st_done, st_fault;
  rcode_e      st_code;
  logic        wait_over, last_poll;

  logic is_ctrl, is_wr, is_rd, cnt_bad;
  assign is_ctrl = (kind_q == KIND_CTRL);
  assign is_wr   = (kind_q == KIND_WRITE);
  assign is_rd   = (kind_q == KIND_READ);
  assign cnt_bad = !is_ctrl && cnt_q[3];

  pwrbus_opc_map u_map (
    .kind (kind_q), .code (code_q), .ok (map_ok), .opc (map_opc)
  );

  pwrbus_cmd_pack #(.SID_W(SID_W), .ADDR_W(ADDR_W)) u_pack (
    .opc (map_opc), .sid (sid_q), .addr (addr_q), .cnt_m1 (cnt_q[2:0]),
    .ctrl (is_ctrl), .wdata (wdata_q), .cmd_word (cmd_word),
    .word0 (word0), .word1 (word1), .keep (keep)
  );

  pwrbus_status_dec u_dec (
    .status (ch_rdata[3:0]), .done (st_done), .fault (st_fault), .code (st_code)
  );

  pwrbus_poll_timer #(.DIV_W(DIV_W), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk (clk), .rst (rst),
    .clear   (st == S_CMD),
    .arm     (st == S_PEVAL && !st_done && !last_poll),
    .tick_en (st == S_WAIT),
    .div (cfg_us_div), .wait_over (wait_over), .last_poll (last_poll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      kind_q  <= '0;
      code_q  <= '0;
      sid_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      wdata_q <= '0;
      rbuf    <= '0;
      rcode_q <= RC_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          kind_q  <= req_kind;
          code_q  <= req_code;
          sid_q   <= req_sid;
          addr_q  <= req_addr;
          cnt_q   <= req_cnt_m1;
          wdata_q <= req_wdata;
          st      <= S_CHECK;
        end
        S_CHECK: begin
          rbuf <= '0;
          if (!map_ok || cnt_bad) begin
            rcode_q <= RC_REJECT;
            st      <= S_RESP;
          end else begin
            st <= is_wr ? S_WD0 : S_CMD;
          end
        end
        S_WD0:  st <= cnt_q[2] ? S_WD1 : S_CMD;
        S_WD1:  st <= S_CMD;
        S_CMD:  st <= S_POLL;
        S_POLL: st <= S_PEVAL;
        S_PEVAL: begin
          if (st_done) begin
            rcode_q <= st_code;
            st      <= (!st_fault && is_rd) ? S_RD0 : S_RESP;
          end else if (last_poll) begin
            rcode_q <= RC_TIMEOUT;
            st      <= S_RESP;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (wait_over) st <= S_POLL;
        S_RD0:  st <= S_RD0C;
        S_RD0C: begin
          rbuf[31:0] <= ch_rdata & keep[31:0];
          st         <= cnt_q[2] ? S_RD1 : S_RESP;
        end
        S_RD1:  st <= S_RD1C;
        S_RD1C: begin
          rbuf[63:32] <= ch_rdata & keep[63:32];
          st          <= S_RESP;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_code  = rcode_q;
  assign rsp_rdata = rbuf;
  assign ch_wr     = (st == S_WD0) || (st == S_WD1) || (st == S_CMD);
  assign ch_rd     = (st == S_POLL) || (st == S_RD0) || (st == S_RD1);

  always_comb begin
    ch_sel   = CH_CMD;
    ch_wdata = '0;
    case (st)
      S_WD0:  begin ch_sel = CH_WD0; ch_wdata = word0; end
      S_WD1:  begin ch_sel = CH_WD1; ch_wdata = word1; end
      S_CMD:  begin ch_sel = CH_CMD; ch_wdata = cmd_word; end
      S_POLL: ch_sel = CH_STATUS;
      S_RD0:  ch_sel = CH_RD0;
      S_RD1:  ch_sel = CH_RD1;
      default: ch_sel = CH_CMD;
    endcase
  end
endmodule

// File: rtl/pwrbus_txn_seq_chk.sv
module pwrbus_txn_seq_chk
  import pwrbus_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        rsp_valid,
  input logic [2:0]  rsp_code,
  input logic [63:0] rsp_rdata,
  input logic        ch_wr,
  input logic        ch_rd,
  input logic [2:0]  ch_sel,
  input logic [31:0] ch_wdata
);
  p_rsp_busy_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy);

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ch_wr && !ch_rd));

  p_rw_excl_r6: assert property (@(posedge clk) disable iff (rst)
    ch_wr |-> !ch_rd);

  p_err_nodata_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 3'd0) |-> (rsp_rdata == 64'd0));

  p_cmd_zero_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (ch_wr && ch_sel == CH_CMD) |-> (ch_wdata[26:24] == 3'd0 && ch_wdata[3] == 1'b0));

  p_code_range_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code <= 3'd5));

  p_cmd_then_poll_r9: assert property (@(posedge clk) disable iff (rst)
    (ch_wr && ch_sel == CH_CMD) |=> (ch_rd && ch_sel == CH_STATUS));
endmodule

bind pwrbus_txn_seq pwrbus_txn_seq_chk u_chk (
  .clk (clk), .rst (rst), .busy (busy), .rsp_valid (rsp_valid),
  .rsp_code (rsp_code), .rsp_rdata (rsp_rdata), .ch_wr (ch_wr),
  .ch_rd (ch_rd), .ch_sel (ch_sel), .ch_wdata (ch_wdata)
);

// File: tb/tb_pwrbus_txn_seq.sv
module tb_pwrbus_txn_seq;
  localparam int MAXP = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_code = '0;
  logic [3:0]  req_sid = '0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_cnt_m1 = '0;
  logic [63:0] req_wdata = '0;
  logic [15:0] cfg_us_div = 16'd2;
  logic        busy, rsp_valid, ch_wr, ch_rd;
  logic [2:0]  rsp_code, ch_sel;
  logic [63:0] rsp_rdata;
  logic [31:0] ch_wdata;
  logic [31:0] ch_rdata = '0;

  always #5 clk = ~clk;

  pwrbus_txn_seq #(.MAX_POLLS(MAXP)) dut (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_kind (req_kind),
    .req_code (req_code), .req_sid (req_sid), .req_addr (req_addr),
    .req_cnt_m1 (req_cnt_m1), .req_wdata (req_wdata), .cfg_us_div (cfg_us_div),
    .busy (busy), .rsp_valid (rsp_valid), .rsp_code (rsp_code),
    .rsp_rdata (rsp_rdata), .ch_wr (ch_wr), .ch_rd (ch_rd), .ch_sel (ch_sel),
    .ch_wdata (ch_wdata), .ch_rdata (ch_rdata)
  );

  int nchk = 0, nfail = 0, rsp_seen = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // channel model
  localparam logic [31:0] RD0_VAL = 32'h8844_2211;
  localparam logic [31:0] RD1_VAL = 32'hF0E0_D0C0;
  int cyc = 0, n_cmd = 0, n_wd0 = 0, n_wd1 = 0, n_rd0 = 0, n_rd1 = 0, n_stat = 0;
  int last_stat = 0, gap_min = 0, gap_max = 0;
  bit order_bad = 0;
  logic [31:0] cap_cmd = '0, cap_wd0 = '0, cap_wd1 = '0;
  int done_after = 1;
  logic [3:0] err_bits = '0;

  always @(posedge clk) begin
    cyc++;
    if (ch_wr) begin
      case (ch_sel)
        3'd0: begin n_cmd++; cap_cmd = ch_wdata; end
        3'd2: begin n_wd0++; cap_wd0 = ch_wdata; if (n_cmd > 0) order_bad = 1; end
        3'd3: begin n_wd1++; cap_wd1 = ch_wdata; if (n_cmd > 0) order_bad = 1; end
        default: ;
      endcase
    end
    if (ch_rd) begin
      case (ch_sel)
        3'd1: begin
          if (n_stat > 0) begin
            if (gap_min == 0 || cyc - last_stat < gap_min) gap_min = cyc - last_stat;
            if (cyc - last_stat > gap_max) gap_max = cyc - last_stat;
          end
          last_stat = cyc;
          n_stat++;
          if (done_after != 0 && n_stat >= done_after) ch_rdata <= {28'h0, err_bits | 4'b0001};
          else ch_rdata <= 32'hFFFF_FFFE;
        end
        3'd4: begin n_rd0++; ch_rdata <= RD0_VAL; end
        3'd5: begin n_rd1++; ch_rdata <= RD1_VAL; end
        default: ;
      endcase
    end
  end

  // scoreboard
  logic [2:0]  q_code[$];
  logic [63:0] q_data[$];
  string       q_tag[$];

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_code.size() == 0) begin
        chk(0, "R11 unexpected response", {61'd0, rsp_code}, 64'd0);
      end else begin
        logic [2:0] ec;
        logic [63:0] ed;
        string t;
        ec = q_code.pop_front();
        ed = q_data.pop_front();
        t  = q_tag.pop_front();
        chk(rsp_code == ec, {t, " result"}, {61'd0, rsp_code}, {61'd0, ec});
        chk(rsp_rdata == ed, {t, " data"}, rsp_rdata, ed);
      end
      rsp_seen++;
    end
  end

  function automatic int model_opc(input logic [1:0] k, input logic [7:0] c);
    int v = int'(c);
    if (k == 2'd0) begin
      if (v >= 'h60 && v <= 'h7F) return 15;
      if (v >= 'h20 && v <= 'h2F) return 13;
      if (v >= 'h38 && v <= 'h3F) return 1;
    end else if (k == 2'd1) begin
      if (v >= 'h40 && v <= 'h5F) return 14;
      if (v <= 'h0F) return 2;
      if (v >= 'h30 && v <= 'h37) return 0;
      if (v >= 'h80) return 16;
    end else if (k == 2'd2) begin
      if (v >= 'h10 && v <= 'h13) return (v | 'h40) & 'h1F;
    end
    return -1;
  endfunction

  function automatic logic [63:0] trim(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (i <= n) r[8*i +: 8] = v[8*i +: 8];
    return r;
  endfunction

  task automatic txn(input logic [1:0] k, input logic [7:0] c, input logic [3:0] sid,
                     input logic [15:0] a, input logic [3:0] n, input logic [63:0] wd,
                     input int dafter, input logic [3:0] eb, input bit poke, input string tag);
    int op, seen, polls;
    bit acc, wr, rd, ctl;
    logic [2:0] ec;
    logic [63:0] ed;
    logic [31:0] ecmd;
    op  = model_opc(k, c);
    ctl = (k == 2'd2);
    wr  = (k == 2'd1);
    rd  = (k == 2'd0);
    acc = (op >= 0) && (ctl || n < 8);
    if (!acc) ec = 3'd1;
    else if (dafter == 0 || dafter > MAXP) ec = 3'd5;
    else if (eb[2]) ec = 3'd2;
    else if (eb[1]) ec = 3'd3;
    else if (eb[3]) ec = 3'd4;
    else ec = 3'd0;
    ed = (ec == 3'd0 && rd) ? trim({RD1_VAL, RD0_VAL}, int'(n)) : 64'd0;
    polls = !acc ? 0 : ((dafter == 0 || dafter > MAXP) ? MAXP : dafter);
    if (ctl) ecmd = {5'(op), 3'b0, sid, 20'd0};
    else     ecmd = {5'(op), 3'b0, sid, a, 1'b0, n[2:0]};
    q_code.push_back(ec);
    q_data.push_back(ed);
    q_tag.push_back(tag);
    n_cmd = 0; n_wd0 = 0; n_wd1 = 0; n_rd0 = 0; n_rd1 = 0; n_stat = 0;
    gap_min = 0; gap_max = 0; order_bad = 0;
    done_after = dafter; err_bits = eb;
    seen = rsp_seen;
    @(negedge clk);
    req_kind = k; req_code = c; req_sid = sid; req_addr = a; req_cnt_m1 = n; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R11 busy after accept", {63'd0, busy}, 64'd1);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_kind = 2'd1; req_code = 8'h45; req_cnt_m1 = 4'd0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (rsp_seen == seen) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(n_cmd == (acc ? 1 : 0), {tag, " cmd writes"}, 64'(n_cmd), 64'(acc));
    chk(n_stat == polls, {tag, " status reads"}, 64'(n_stat), 64'(polls));
    if (acc) chk(cap_cmd == ecmd, {tag, " R4 command word"}, {32'd0, cap_cmd}, {32'd0, ecmd});
    chk(n_wd0 == ((acc && wr) ? 1 : 0), {tag, " R6 word0 writes"}, 64'(n_wd0), 64'(acc && wr));
    chk(n_wd1 == ((acc && wr && n > 3) ? 1 : 0), {tag, " R6 word1 writes"}, 64'(n_wd1), 64'(acc && wr && n > 3));
    if (acc && wr) begin
      logic [63:0] ew = trim(wd, int'(n));
      chk(cap_wd0 == ew[31:0], {tag, " R6 word0"}, {32'd0, cap_wd0}, {32'd0, ew[31:0]});
      if (n > 3) chk(cap_wd1 == ew[63:32], {tag, " R6 word1"}, {32'd0, cap_wd1}, {32'd0, ew[63:32]});
      chk(!order_bad, {tag, " R6 data before command"}, 64'(order_bad), 64'd0);
    end
    chk(n_rd0 == ((rd && ec == 3'd0) ? 1 : 0), {tag, " R7 word0 reads"}, 64'(n_rd0), 64'(rd && ec == 3'd0));
    chk(n_rd1 == ((rd && ec == 3'd0 && n > 3) ? 1 : 0), {tag, " R7 word1 reads"}, 64'(n_rd1), 64'(rd && ec == 3'd0 && n > 3));
    chk(busy == 1'b0, {tag, " R11 idle after response"}, {63'd0, busy}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R12 busy in reset", {63'd0, busy}, 64'd0);
    chk(rsp_valid == 1'b0, "R12 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(n_cmd + n_stat + n_wd0 == 0, "R12 no access after reset", 64'(n_cmd + n_stat), 64'd0);
    chk(busy == 1'b0, "R12 idle after reset", {63'd0, busy}, 64'd0);

    // read mapping
    txn(2'd0, 8'h60, 4'h3, 16'h1234, 4'd1, 64'd0, 1, 4'h0, 0, "R1 read 0x60");
    txn(2'd0, 8'h7F, 4'hA, 16'hBEEF, 4'd7, 64'd0, 3, 4'h0, 0, "R1 R9 read 0x7F");
    txn(2'd0, 8'h25, 4'h1, 16'h0101, 4'd4, 64'd0, 2, 4'h0, 0, "R1 R7 read 0x25");
    txn(2'd0, 8'h3A, 4'hF, 16'hFFFF, 4'd0, 64'd0, 1, 4'h0, 0, "R1 read 0x3A");
    txn(2'd0, 8'h50, 4'h2, 16'h0000, 4'd0, 64'd0, 1, 4'h0, 0, "R1 read reject");
    txn(2'd3, 8'h60, 4'h2, 16'h0000, 4'd0, 64'd0, 1, 4'h0, 0, "R1 kind3 reject");
    // write mapping
    txn(2'd1, 8'h45, 4'h5, 16'h0A0B, 4'd2, 64'h1122334455667788, 1, 4'h0, 0, "R2 R6 write 0x45");
    txn(2'd1, 8'h00, 4'h6, 16'h00FF, 4'd7, 64'h0102030405060708, 2, 4'h0, 0, "R2 R6 write 0x00");
    txn(2'd1, 8'h33, 4'h7, 16'h7777, 4'd4, 64'hCAFEBABEDEADBEEF, 1, 4'h0, 0, "R2 write 0x33");
    txn(2'd1, 8'h80, 4'h8, 16'h8000, 4'd3, 64'hA5A5A5A55A5A5A5A, 1, 4'h0, 0, "R2 write 0x80");
    txn(2'd1, 8'hFF, 4'h9, 16'h9000, 4'd0, 64'h00000000000000AB, 1, 4'h0, 0, "R2 write 0xFF");
    txn(2'd1, 8'h38, 4'h9, 16'h9000, 4'd0, 64'd1, 1, 4'h0, 0, "R2 write reject");
    // byte count limit
    txn(2'd1, 8'h45, 4'h1, 16'h0001, 4'd8, 64'd5, 1, 4'h0, 0, "R5 write count 9");
    txn(2'd0, 8'h60, 4'h1, 16'h0001, 4'd15, 64'd0, 1, 4'h0, 0, "R5 read count 16");
    // control
    txn(2'd2, 8'h10, 4'hC, 16'hFFFF, 4'd15, 64'hFF, 1, 4'h0, 0, "R3 control 0x10");
    txn(2'd2, 8'h13, 4'h4, 16'h1234, 4'd2, 64'd0, 2, 4'h0, 0, "R3 control 0x13");
    txn(2'd2, 8'h14, 4'h4, 16'h1234, 4'd2, 64'd0, 1, 4'h0, 0, "R3 control reject");
    // status priority
    txn(2'd0, 8'h61, 4'h2, 16'h2222, 4'd5, 64'd0, 1, 4'b1110, 0, "R8 R7 denied");
    txn(2'd1, 8'h41, 4'h2, 16'h2222, 4'd1, 64'h1234, 1, 4'b1010, 0, "R8 failed");
    txn(2'd0, 8'h62, 4'h2, 16'h2222, 4'd0, 64'd0, 2, 4'b1000, 0, "R8 dropped");
    // timeout and interval
    cfg_us_div = 16'd3;
    txn(2'd0, 8'h60, 4'h1, 16'h0042, 4'd7, 64'd0, 0, 4'h0, 0, "R9 timeout");
    chk(gap_min == 5 && gap_max == 5, "R10 interval div=3", 64'(gap_min), 64'd5);
    txn(2'd0, 8'h60, 4'h1, 16'h0043, 4'd6, 64'd0, MAXP, 4'h0, 0, "R9 done on last poll");
    cfg_us_div = 16'd0;
    txn(2'd1, 8'h40, 4'h1, 16'h0044, 4'd0, 64'h77, 4, 4'h0, 0, "R10 div zero");
    chk(gap_min == 3 && gap_max == 3, "R10 interval div=0", 64'(gap_max), 64'd3);
    // request while busy
    cfg_us_div = 16'd2;
    txn(2'd0, 8'h2A, 4'h5, 16'h5555, 4'd3, 64'd0, 6, 4'h0, 1, "R11 request while busy");
    chk(q_code.size() == 0, "R11 no extra response", 64'(q_code.size()), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule